// File: doc/BRIEF.md
# Effective Address Generation Sequencer

This block works out the operand address for an 8-bit accumulator processor with a 16-bit address space. The core hands it a 4-bit addressing-mode code, the program counter that points just past the opcode, and the current X and Y index values, then pulses `start`. The sequencer fetches whatever operand and pointer bytes the mode needs through a byte-wide synchronous read port. It issues one request at a time and waits one cycle for each returned byte. It finishes with a single-cycle `done` pulse and presents the 16-bit effective address and the advanced program counter.

Zero-page arithmetic wraps inside page 0. Every 16-bit value held in memory has its low byte at the lower address. Post-indexed indirect adds Y only after the pointer has been read. An unused mode code finishes at once with `err` raised alongside `done`.

The control is a single enumerated state machine. `S_IDLE` waits for `start`. From there, a mode that needs no fetch goes to `S_FIN`, and every other mode goes to `S_REQ_OPL`. The fetch pairs run in this order: `S_REQ_OPL` to `S_GET_OPL`, then `S_REQ_OPH` to `S_GET_OPH`, then `S_REQ_PTL` to `S_GET_PTL`, then `S_REQ_PTH` to `S_GET_PTH`. The mode decides the exits:
- `S_GET_OPL` goes to `S_REQ_OPH` for a two-byte operand, to `S_REQ_PTL` for a zero-page pointer, and to `S_FIN` otherwise.
- `S_GET_OPH` goes to `S_REQ_PTL` for absolute indirect, and to `S_FIN` otherwise.
- `S_GET_PTH` goes to `S_FIN`.
- `S_FIN` raises `done` and returns to `S_IDLE`.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, `done`, `err` and `mem_rd` are all 0.
- R2: Mode code 0 (immediate) makes no memory read. `ea` equals `pc_in`, `pc_out` equals `pc_in`+1 (mod 65536), and `done` is high in the cycle after the `start` edge.
- R3: Mode codes 1, 2 and 3 (zero page, zero page + X, zero page + Y) read one operand byte at `pc_in`. The index is added modulo 256, and the high address byte is 0. `pc_out` is `pc_in`+1, and `done` comes 3 cycles after the `start` edge.
- R4: Mode codes 4, 5 and 6 (absolute, absolute + X, absolute + Y) read the low byte at `pc_in` and the high byte at `pc_in`+1. X or Y is added with a carry into the high byte. `pc_out` is `pc_in`+2, and `done` comes 5 cycles after `start`.
- R5: Mode code 7 (absolute indirect) reads a 16-bit operand P, then reads the low byte at P and the high byte at P+1. P+1 carries into the high byte, including when P's low byte is $FF. The two bytes form `ea`. `pc_out` is `pc_in`+2, and `done` comes 9 cycles after `start`.
- R6: Mode code 8 (pre-indexed indirect) forms Z = (operand + X) mod 256. It reads the pointer low byte at $00Z and the high byte at $00(Z+1 mod 256), so Z = $FF takes its high byte from $0000. The pointer is `ea`. `pc_out` is `pc_in`+1, and `done` comes 7 cycles after `start`.
- R7: Mode code 9 (post-indexed indirect) reads a pointer from zero page at the operand, with the same page-0 wrap for the high byte. It then adds Y to the 16-bit pointer with carry. `pc_out` is `pc_in`+1, and `done` comes 7 cycles after `start`.
- R8: Mode codes 10 to 15 make no memory read. `done` and `err` are both high in the cycle after `start`, with `ea` and `pc_out` both equal to `pc_in`.
- R9: A `start` pulse while an address is being generated is ignored. The result and latency of the operation in progress are unchanged.
- R10: `mem_rd` is never high in two consecutive cycles, and each request is followed by a cycle that captures its data.
- R11: `done` is high for exactly one cycle per accepted `start`, and `err` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation, taken only in idle |
| mode | input | 4 | Addressing-mode code, 0 to 9 valid |
| pc_in | input | 16 | Program counter, pointing at the first operand byte |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| mem_rd | output | 1 | Read request, one byte |
| mem_addr | output | 16 | Read address, valid while `mem_rd` is high |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unused mode code, high only with `done` |
| ea | output | 16 | Effective address, valid while `done` is high |
| pc_out | output | 16 | Advanced program counter, valid while `done` is high |

## Verification
The hardest cases to reach are those where a wrap happens at a byte fetched from memory: a zero-page pointer sitting at $FF, and an indirect pointer whose low byte is $FF and must carry into the next page. The memory model therefore returns a fixed byte computed from the address, with specific locations overridden, so the pointer chains can be placed exactly on those boundaries. A stray `start` pulse is also injected in the middle of a long absolute-indirect fetch. This shows that the busy machine drops it without disturbing either the read count or the result.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        M_IMM  = 4'd0,
        M_ZP   = 4'd1,
        M_ZPX  = 4'd2,
        M_ZPY  = 4'd3,
        M_ABS  = 4'd4,
        M_ABSX = 4'd5,
        M_ABSY = 4'd6,
        M_IND  = 4'd7,
        M_INDX = 4'd8,
        M_INDY = 4'd9
    } mode_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_X    = 2'd1,
        IX_Y    = 2'd2
    } idx_sel_e;

    typedef enum logic [1:0] {
        PT_NONE = 2'd0,
        PT_ZP   = 2'd1,
        PT_FULL = 2'd2
    } ptr_kind_e;

    typedef struct packed {
        logic      legal;
        logic      no_fetch;
        logic      two_byte;
        idx_sel_e  op_idx;
        idx_sel_e  ptr_idx;
        ptr_kind_e ptr;
    } mode_attr_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ_OPL,
        S_GET_OPL,
        S_REQ_OPH,
        S_GET_OPH,
        S_REQ_PTL,
        S_GET_PTL,
        S_REQ_PTH,
        S_GET_PTH,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/ea_mode_info.sv
module ea_mode_info
    import ea_pkg::*;
#(
    parameter int MW = 4
) (
    input  logic [MW-1:0] code,
    output mode_attr_t    attr
);

    always_comb begin
        attr = '{legal: 1'b1, no_fetch: 1'b0, two_byte: 1'b0,
                 op_idx: IX_NONE, ptr_idx: IX_NONE, ptr: PT_NONE};
        unique case (code)
            MW'(M_IMM):  attr.no_fetch = 1'b1;
            MW'(M_ZP):   ;
            MW'(M_ZPX):  attr.op_idx = IX_X;
            MW'(M_ZPY):  attr.op_idx = IX_Y;
            MW'(M_ABS):  attr.two_byte = 1'b1;
            MW'(M_ABSX): begin
                attr.two_byte = 1'b1;
                attr.op_idx   = IX_X;
            end
            MW'(M_ABSY): begin
                attr.two_byte = 1'b1;
                attr.op_idx   = IX_Y;
            end
            MW'(M_IND):  begin
                attr.two_byte = 1'b1;
                attr.ptr      = PT_FULL;
            end
            MW'(M_INDX): begin
                attr.op_idx = IX_X;
                attr.ptr    = PT_ZP;
            end
            MW'(M_INDY): begin
                attr.ptr     = PT_ZP;
                attr.ptr_idx = IX_Y;
            end
            default: begin
                attr.legal    = 1'b0;
                attr.no_fetch = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    input  logic          wrap_page,
    output logic [AW-1:0] sum
);

    logic [DW-1:0] low_sum;

    assign low_sum = base[DW-1:0] + idx;
    assign sum = wrap_page ? {base[AW-1:DW], low_sum}
                           : base + {{(AW-DW){1'b0}}, idx};

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int DW = 8,
    parameter int MW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MW-1:0]    mode,
    input  logic [2*DW-1:0]  pc_in,
    input  logic [DW-1:0]    x_idx,
    input  logic [DW-1:0]    y_idx,
    output logic             mem_rd,
    output logic [2*DW-1:0]  mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic             err,
    output logic [2*DW-1:0]  ea,
    output logic [2*DW-1:0]  pc_out
);

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [DW-1:0] ONE_D = DW'(1);
    localparam logic [MW-1:0] LAST_CODE = MW'(M_INDY);

    seq_state_e state, state_nx;
    mode_attr_t attr_in;

    logic            two_byte_r;
    idx_sel_e        op_idx_r, ptr_idx_r;
    ptr_kind_e       ptr_r;
    logic [DW-1:0]   x_r, y_r, opl_r, ptl_r;
    logic [AW-1:0]   pc_r, ptr_addr_r, ea_r;
    logic            err_r;

    logic [DW-1:0]   op_idx_val, ptr_idx_val;
    logic [AW-1:0]   op_base, op_sum, ptr_word, fin_sum, ptr_hi_addr;

    ea_mode_info #(.MW(MW)) u_dec (
        .code (mode),
        .attr (attr_in)
    );

    always_comb begin
        unique case (op_idx_r)
            IX_X:    op_idx_val = x_r;
            IX_Y:    op_idx_val = y_r;
            default: op_idx_val = '0;
        endcase
        unique case (ptr_idx_r)
            IX_X:    ptr_idx_val = x_r;
            IX_Y:    ptr_idx_val = y_r;
            default: ptr_idx_val = '0;
        endcase
    end

    assign op_base  = two_byte_r ? {mem_rdata, opl_r} : {{DW{1'b0}}, mem_rdata};
    assign ptr_word = {mem_rdata, ptl_r};

    ea_index_add #(.DW(DW), .AW(AW)) u_op_add (
        .base      (op_base),
        .idx       (op_idx_val),
        .wrap_page (!two_byte_r),
        .sum       (op_sum)
    );

    ea_index_add #(.DW(DW), .AW(AW)) u_ptr_add (
        .base      (ptr_word),
        .idx       (ptr_idx_val),
        .wrap_page (1'b0),
        .sum       (fin_sum)
    );

    ea_index_add #(.DW(DW), .AW(AW)) u_hi_add (
        .base      (ptr_addr_r),
        .idx       (ONE_D),
        .wrap_page (ptr_r == PT_ZP),
        .sum       (ptr_hi_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = attr_in.no_fetch ? S_FIN : S_REQ_OPL;
            S_REQ_OPL: state_nx = S_GET_OPL;
            S_GET_OPL: begin
                if (two_byte_r)           state_nx = S_REQ_OPH;
                else if (ptr_r != PT_NONE) state_nx = S_REQ_PTL;
                else                       state_nx = S_FIN;
            end
            S_REQ_OPH: state_nx = S_GET_OPH;
            S_GET_OPH: state_nx = (ptr_r == PT_FULL) ? S_REQ_PTL : S_FIN;
            S_REQ_PTL: state_nx = S_GET_PTL;
            S_GET_PTL: state_nx = S_REQ_PTH;
            S_REQ_PTH: state_nx = S_GET_PTH;
            S_GET_PTH: state_nx = S_FIN;
            S_FIN:     state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = pc_r;
        unique case (state)
            S_REQ_OPL, S_REQ_OPH: mem_rd = 1'b1;
            S_REQ_PTL: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_addr_r;
            end
            S_REQ_PTH: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_hi_addr;
            end
            default: ;
        endcase
    end

    assign done   = (state == S_FIN);
    assign err    = done & err_r;
    assign ea     = ea_r;
    assign pc_out = pc_r;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            two_byte_r <= 1'b0;
            op_idx_r   <= IX_NONE;
            ptr_idx_r  <= IX_NONE;
            ptr_r      <= PT_NONE;
            x_r        <= '0;
            y_r        <= '0;
            opl_r      <= '0;
            ptl_r      <= '0;
            pc_r       <= '0;
            ptr_addr_r <= '0;
            ea_r       <= '0;
            err_r      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    two_byte_r <= attr_in.two_byte;
                    op_idx_r   <= attr_in.op_idx;
                    ptr_idx_r  <= attr_in.ptr_idx;
                    ptr_r      <= attr_in.ptr;
                    x_r        <= x_idx;
                    y_r        <= y_idx;
                    ea_r       <= pc_in;
                    err_r      <= !attr_in.legal;
                    pc_r       <= (attr_in.no_fetch && attr_in.legal) ? pc_in + ONE_A : pc_in;
                end
                S_REQ_OPL, S_REQ_OPH: pc_r <= pc_r + ONE_A;
                S_GET_OPL: begin
                    opl_r <= mem_rdata;
                    if (!two_byte_r) begin
                        if (ptr_r != PT_NONE) ptr_addr_r <= op_sum;
                        else                  ea_r       <= op_sum;
                    end
                end
                S_GET_OPH: begin
                    if (ptr_r == PT_FULL) ptr_addr_r <= op_sum;
                    else                  ea_r       <= op_sum;
                end
                S_GET_PTL: ptl_r <= mem_rdata;
                S_GET_PTH: ea_r  <= fin_sum;
                S_FIN:     err_r <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R11
    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);                                                        // R11
    AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);                                                  // R10
    AST_IMM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && mode == MW'(M_IMM)) |=>
            (done && !err && ea == $past(pc_in) && pc_out == $past(pc_in) + ONE_A)); // R2
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && mode > LAST_CODE) |=>
            (done && err && pc_out == $past(pc_in)));                         // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_FIN && start) |=> (state != S_IDLE));  // R9

endmodule

// File: tb/tb_ea_sequencer.sv
`timescale 1ns/1ps
module tb_ea_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_idx = '0;
    logic [7:0]  y_idx = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done, err;
    logic [15:0] ea, pc_out;

    always #4 clk = ~clk;

    ea_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
        .x_idx(x_idx), .y_idx(y_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .err(err), .ea(ea), .pc_out(pc_out)
    );

    logic [7:0] ovr [int];

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        if (ovr.exists(int'(a))) return ovr[int'(a)];
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_at(mem_addr);

    int cyc = 0, rd_cnt = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) rd_cnt <= rd_cnt + 1;
    end

    typedef struct {
        logic [15:0] ea;
        logic [15:0] pc;
        logic        err;
        int          lat;
        int          nrd;
        int          req;
        int          t0;
        int          r0;
    } item_t;

    item_t sb[$];
    item_t cur;
    int n_chk = 0, n_bad = 0;
    int rd_back = 0, dbl_done = 0;
    logic prev_rd = 1'b0, prev_done = 1'b0;

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference model written from the requirements
    function automatic item_t model(input logic [3:0] m, input logic [15:0] p,
                                    input logic [7:0] xv, input logic [7:0] yv);
        item_t e;
        logic [7:0]  o, z;
        logic [15:0] w;
        e = '{ea: p, pc: p, err: 1'b0, lat: 1, nrd: 0, req: 0, t0: 0, r0: 0};
        o = mem_at(p);
        w = {mem_at(p + 16'd1), o};
        case (m)
            4'd0: e.pc = p + 16'd1;
            4'd1, 4'd2, 4'd3: begin
                z = (m == 4'd2) ? o + xv : (m == 4'd3) ? o + yv : o;
                e.ea = {8'h00, z}; e.pc = p + 16'd1; e.lat = 3; e.nrd = 1;
            end
            4'd4, 4'd5, 4'd6: begin
                e.ea = (m == 4'd5) ? w + {8'h00, xv} : (m == 4'd6) ? w + {8'h00, yv} : w;
                e.pc = p + 16'd2; e.lat = 5; e.nrd = 2;
            end
            4'd7: begin
                e.ea = {mem_at(w + 16'd1), mem_at(w)};
                e.pc = p + 16'd2; e.lat = 9; e.nrd = 4;
            end
            4'd8, 4'd9: begin
                z = (m == 4'd8) ? o + xv : o;
                e.ea = {mem_at({8'h00, z + 8'd1}), mem_at({8'h00, z})};
                if (m == 4'd9) e.ea = e.ea + {8'h00, yv};
                e.pc = p + 16'd1; e.lat = 7; e.nrd = 3;
            end
            default: e.err = 1'b1;
        endcase
        return e;
    endfunction

    // Monitor: pops expected items as the design completes
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, 11, "done with no pending item", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(ea == cur.ea, cur.req, "ea", ea, cur.ea);
                    chk(pc_out == cur.pc, cur.req, "pc_out", pc_out, cur.pc);
                    chk(err == cur.err, cur.req, "err", err, cur.err);
                    chk(cyc - cur.t0 == cur.lat, cur.req, "latency", cyc - cur.t0, cur.lat);
                    chk(rd_cnt - cur.r0 == cur.nrd, cur.req, "reads", rd_cnt - cur.r0, cur.nrd);
                end
            end
            if (mem_rd && prev_rd) rd_back++;
            if (done && prev_done) dbl_done++;
        end
        prev_rd   = mem_rd;
        prev_done = done;
    end

    task automatic run(input logic [3:0] m, input logic [15:0] p, input logic [7:0] xv,
                       input logic [7:0] yv, input int req, input bit glitch);
        item_t e;
        int w;
        e = model(m, p, xv, yv);
        e.req = req;
        e.t0  = cyc;
        e.r0  = rd_cnt;
        sb.push_back(e);
        mode = m; pc_in = p; x_idx = xv; y_idx = yv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            mode = 4'd0; pc_in = 16'hDEAD; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            mode = 4'd12; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 60) begin
            @(negedge clk);
            w++;
        end
        if (!done) begin
            chk(1'b0, req, "timeout waiting for done", 0, 1);
            void'(sb.pop_back());
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, 0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        ovr['h0200] = 8'h37;  ovr['h0210] = 8'hF0;  ovr['h0220] = 8'h80;
        ovr['h0300] = 8'h34;  ovr['h0301] = 8'h12;
        ovr['h0310] = 8'hFF;  ovr['h0311] = 8'h12;
        ovr['h0320] = 8'hF0;  ovr['h0321] = 8'h40;
        ovr['h0400] = 8'hFF;  ovr['h0401] = 8'h20;
        ovr['h20FF] = 8'h78;  ovr['h2100] = 8'h56;
        ovr['h0500] = 8'hF0;  ovr['h0510] = 8'h10;
        ovr['h00FF] = 8'hCD;  ovr['h0000] = 8'hAB;
        ovr['h0015] = 8'h22;  ovr['h0016] = 8'h11;
        ovr['h0600] = 8'h40;  ovr['h0610] = 8'hFF;
        ovr['h0040] = 8'hF0;  ovr['h0041] = 8'h33;

        // R1: quiet outputs during and just after reset
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_rd, 1, "outputs in reset", {done, err, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err && !mem_rd, 1, "outputs after reset", {done, err, mem_rd}, 0);

        run(4'd0, 16'h1234, 8'h00, 8'h00, 2, 1'b0);   // R2 immediate
        run(4'd0, 16'hFFFF, 8'h00, 8'h00, 2, 1'b0);   // R2 pc wrap
        run(4'd1, 16'h0200, 8'h55, 8'h66, 3, 1'b0);   // R3 zero page
        run(4'd2, 16'h0210, 8'h20, 8'h00, 3, 1'b0);   // R3 zp+X wraps to $0010
        run(4'd3, 16'h0220, 8'h00, 8'h7F, 3, 1'b0);   // R3 zp+Y gives $00FF
        run(4'd4, 16'h0300, 8'h11, 8'h22, 4, 1'b0);   // R4 absolute
        run(4'd5, 16'h0310, 8'h01, 8'h00, 4, 1'b0);   // R4 abs+X carries to $1300
        run(4'd6, 16'h0320, 8'h00, 8'hFF, 4, 1'b0);   // R4 abs+Y carries
        run(4'd7, 16'h0400, 8'h00, 8'h00, 5, 1'b0);   // R5 indirect, pointer crosses page
        run(4'd8, 16'h0500, 8'h0F, 8'h00, 6, 1'b0);   // R6 pointer at $FF, high from $0000
        run(4'd8, 16'h0510, 8'h05, 8'h00, 6, 1'b0);   // R6 plain pointer at $15
        run(4'd9, 16'h0600, 8'h00, 8'h20, 7, 1'b0);   // R7 Y added after read
        run(4'd9, 16'h0610, 8'h00, 8'h01, 7, 1'b0);   // R7 pointer wrap at $FF
        run(4'd10, 16'h4567, 8'h00, 8'h00, 8, 1'b0);  // R8 unused code
        run(4'd15, 16'h89AB, 8'h00, 8'h00, 8, 1'b0);  // R8 unused code
        run(4'd7, 16'h0400, 8'h00, 8'h00, 9, 1'b1);   // R9 start pulses while busy
        run(4'd5, 16'h0310, 8'h01, 8'h00, 9, 1'b1);   // R9 start pulses while busy

        repeat (3) @(negedge clk);
        chk(rd_back == 0, 10, "back-to-back reads", rd_back, 0);      // R10
        chk(dbl_done == 0, 11, "done wider than a cycle", dbl_done, 0); // R11
        chk(sb.size() == 0, 11, "missing done pulses", sb.size(), 0);   // R11
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule